// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data between one narrow word port (A) and a wide port made of two halves of the same width (1B and 2B). Going from narrow to wide, two narrow words arriving on consecutive captures are gathered and released together, so the wide side sees one double-width word. Going from wide to narrow, both halves are captured into their own stores, and a select input picks which stored half drives the narrow side.

Every control input acts only on the rising clock edge. This includes the four active-low per-path load enables, the half select and the two active-low port drive enables. A change of direction therefore always lines up with a clock edge. Each bidirectional port is split into an input bus, an output bus and a one-bit drive flag. The pad logic outside the block combines these three into a tri-state driver.

A synchronous active-high reset clears every data register and releases both ports. A system that uses the block applies reset before its first transfer.

Top module: `wide_narrow_xchg`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears every data register to zero and sets both `a_drive` and `b_drive` to 0.
- R2: The narrow-to-1B path has two register stages. The first stage captures `a_in` on an edge where `ab1_ld_n` is 0. The `b1_out` register captures the first stage on an edge where `ab2_ld_n` is 0.
- R3: `b2_out` captures `a_in` on an edge where `ab2_ld_n` is 0. A word X presented with `ab1_ld_n`=0, followed on the next edge by a word Y presented with `ab2_ld_n`=0, leaves `b1_out`=X and `b2_out`=Y together after the second edge.
- R4: A word presented with only `ab1_ld_n` low does not reach `b1_out` or `b2_out` on that edge. It needs a second edge with `ab2_ld_n` low.
- R5: On an edge where `ab2_ld_n` is 1, `b1_out` and `b2_out` keep their values whatever `a_in` and `ab1_ld_n` do.
- R6: The 1B store captures `b1_in` on an edge where `b1a_ld_n` is 0. The 2B store captures `b2_in` on an edge where `b2a_ld_n` is 0. A store whose enable is 1 keeps its value.
- R7: On an edge where `b1a_ld_n` or `b2a_ld_n` is 0, `a_out` loads the value the selected store holds after that edge. `sel`=1 selects the 1B store and `sel`=0 selects the 2B store, even when the selected store's own enable is 1.
- R8: On an edge where both `b1a_ld_n` and `b2a_ld_n` are 1, `a_out` holds its value, even if `sel`, `b1_in` or `b2_in` change.
- R9: `a_drive` and `b_drive` change only at a rising edge. After an edge each equals the inverse of its enable (`a_oe_n`, `b_oe_n`) as sampled at that edge.
- R10: The two drive flags are independent. All four combinations, including both driving and both released, are reachable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Narrow port input data |
| ab1_ld_n | input | 1 | Active-low load of the first narrow-to-1B stage |
| ab2_ld_n | input | 1 | Active-low load of the 1B and 2B output registers |
| b1_in | input | W | 1B half input data |
| b2_in | input | W | 2B half input data |
| b1a_ld_n | input | 1 | Active-low load of the 1B store |
| b2a_ld_n | input | 1 | Active-low load of the 2B store |
| sel | input | 1 | Half select for the narrow output (1 = 1B, 0 = 2B) |
| a_oe_n | input | 1 | Active-low narrow port drive enable, registered |
| b_oe_n | input | 1 | Active-low wide port drive enable, registered |
| a_out | output | W | Narrow port output data |
| a_drive | output | 1 | Narrow port drive flag |
| b1_out | output | W | 1B half output data |
| b2_out | output | W | 2B half output data |
| b_drive | output | 1 | Wide port drive flag |

## Verification
The bench sweeps word pairs through the gather path and checks that both halves appear together only after the edge that carries the second enable. A design that gave the 1B path a single stage would show the later word on both halves. A design that ignored the first-stage enable would show a stale or wrong first word.

On the wide-to-narrow side, the bench checks three cases:
- It selects a half whose own enable is inactive while the other half loads. A design that gated the output by the selected half's enable would keep an old value.
- It changes the select with both enables inactive. A design that muxed combinationally would follow the change.
- It asserts reset between the two gather captures. A design that failed to clear the first stage would leak the old word into the 1B half.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  // which stored half feeds the narrow port
  typedef enum logic {
    PICK_2B = 1'b0,
    PICK_1B = 1'b1
  } half_pick_e;

  localparam int unsigned NUM_HALVES = 2;
  localparam int unsigned NUM_PORTS  = 2;
  localparam int unsigned IDX_1B     = 0;
  localparam int unsigned IDX_2B     = 1;
  localparam int unsigned PORT_A     = 0;
  localparam int unsigned PORT_B     = 1;
endpackage

// File: rtl/xchg_gather.sv
module xchg_gather #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         first_ld_n,
  input  logic         pair_ld_n,
  output logic [W-1:0] b1_q,
  output logic [W-1:0] b2_q
);
  logic [W-1:0] stage1_q;

  // first stage of the 1B pipeline
  always_ff @(posedge clk) begin
    if (rst)              stage1_q <= '0;
    else if (!first_ld_n) stage1_q <= a_in;
  end

  // both wide halves update on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      b1_q <= '0;
      b2_q <= '0;
    end else if (!pair_ld_n) begin
      b1_q <= stage1_q;
      b2_q <= a_in;
    end
  end
endmodule

// File: rtl/xchg_pick.sv
module xchg_pick
  import xchg_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_HALVES-1:0][W-1:0]   half_in,
  input  logic [NUM_HALVES-1:0]          half_ld_n,
  input  logic                           sel,
  output logic [W-1:0]                   a_q
);
  logic [NUM_HALVES-1:0][W-1:0] store_q;
  logic [NUM_HALVES-1:0][W-1:0] store_nxt;
  half_pick_e                   pick;
  logic                         any_ld;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_store
    always_comb store_nxt[h] = half_ld_n[h] ? store_q[h] : half_in[h];

    always_ff @(posedge clk) begin
      if (rst) store_q[h] <= '0;
      else     store_q[h] <= store_nxt[h];
    end
  end

  always_comb begin
    pick   = half_pick_e'(sel);
    any_ld = ~&half_ld_n;
  end

  always_ff @(posedge clk) begin
    if (rst) a_q <= '0;
    else if (any_ld) begin
      a_q <= (pick == PICK_1B) ? store_nxt[IDX_1B] : store_nxt[IDX_2B];
    end
  end
endmodule

// File: rtl/xchg_drive.sv
module xchg_drive #(
  parameter int unsigned P = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [P-1:0] oe_n,
  output logic [P-1:0] drive_q
);
  for (genvar p = 0; p < P; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) drive_q[p] <= 1'b0;
      else     drive_q[p] <= ~oe_n[p];
    end
  end
endmodule

// File: rtl/wide_narrow_xchg.sv
module wide_narrow_xchg
  import xchg_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         ab1_ld_n,
  input  logic         ab2_ld_n,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  input  logic         b1a_ld_n,
  input  logic         b2a_ld_n,
  input  logic         sel,
  input  logic         a_oe_n,
  input  logic         b_oe_n,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  output logic [W-1:0] b1_out,
  output logic [W-1:0] b2_out,
  output logic         b_drive
);
  logic [NUM_HALVES-1:0][W-1:0] halves_in;
  logic [NUM_HALVES-1:0]        halves_ld_n;
  logic [NUM_PORTS-1:0]         oe_n_vec;
  logic [NUM_PORTS-1:0]         drive_vec;

  always_comb begin
    halves_in[IDX_1B]   = b1_in;
    halves_in[IDX_2B]   = b2_in;
    halves_ld_n[IDX_1B] = b1a_ld_n;
    halves_ld_n[IDX_2B] = b2a_ld_n;
    oe_n_vec[PORT_A]    = a_oe_n;
    oe_n_vec[PORT_B]    = b_oe_n;
    a_drive             = drive_vec[PORT_A];
    b_drive             = drive_vec[PORT_B];
  end

  xchg_gather #(.W(W)) u_gather (
    .clk        (clk),
    .rst        (rst),
    .a_in       (a_in),
    .first_ld_n (ab1_ld_n),
    .pair_ld_n  (ab2_ld_n),
    .b1_q       (b1_out),
    .b2_q       (b2_out)
  );

  xchg_pick #(.W(W)) u_pick (
    .clk       (clk),
    .rst       (rst),
    .half_in   (halves_in),
    .half_ld_n (halves_ld_n),
    .sel       (sel),
    .a_q       (a_out)
  );

  xchg_drive #(.P(NUM_PORTS)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .oe_n    (oe_n_vec),
    .drive_q (drive_vec)
  );
endmodule

// File: rtl/xchg_checker.sv
module xchg_checker #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic         ab1_ld_n,
  input logic         ab2_ld_n,
  input logic [W-1:0] b1_in,
  input logic [W-1:0] b2_in,
  input logic         b1a_ld_n,
  input logic         b2a_ld_n,
  input logic         sel,
  input logic         a_oe_n,
  input logic         b_oe_n,
  input logic [W-1:0] a_out,
  input logic         a_drive,
  input logic [W-1:0] b1_out,
  input logic [W-1:0] b2_out,
  input logic         b_drive
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (a_out == '0 && b1_out == '0 && b2_out == '0 && !a_drive && !b_drive));

  assert_two_stage_1b_R2: assert property (@(posedge clk) disable iff (rst)
    (!ab2_ld_n && $past(!ab1_ld_n) && $past(!rst)) |=> (b1_out == $past(a_in, 2)));

  assert_2b_capture_R3: assert property (@(posedge clk) disable iff (rst)
    !ab2_ld_n |=> (b2_out == $past(a_in)));

  assert_b_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ab2_ld_n |=> ($stable(b1_out) && $stable(b2_out)));

  assert_pick_1b_R7: assert property (@(posedge clk) disable iff (rst)
    (!b1a_ld_n && sel) |=> (a_out == $past(b1_in)));

  assert_pick_2b_R7: assert property (@(posedge clk) disable iff (rst)
    (!b2a_ld_n && !sel) |=> (a_out == $past(b2_in)));

  assert_a_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (b1a_ld_n && b2a_ld_n) |=> $stable(a_out));

  assert_drive_follow_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (a_drive == !$past(a_oe_n) && b_drive == !$past(b_oe_n)));
endmodule

bind wide_narrow_xchg xchg_checker #(.W(W)) u_chk (.*);

// File: tb/wide_narrow_xchg_tb.sv
module wide_narrow_xchg_tb;
  localparam int unsigned W = 12;
  localparam logic [W-1:0] MASK = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic         ab1_ld_n = 1'b1;
  logic         ab2_ld_n = 1'b1;
  logic [W-1:0] b1_in = '0;
  logic [W-1:0] b2_in = '0;
  logic         b1a_ld_n = 1'b1;
  logic         b2a_ld_n = 1'b1;
  logic         sel = 1'b0;
  logic         a_oe_n = 1'b1;
  logic         b_oe_n = 1'b1;
  logic [W-1:0] a_out;
  logic         a_drive;
  logic [W-1:0] b1_out;
  logic [W-1:0] b2_out;
  logic         b_drive;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  wide_narrow_xchg #(.W(W)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one rising edge; returns at the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  logic [W-1:0] exp1, exp2, st1, st2, expa;

  initial begin
    @(negedge clk);
    step();
    step();
    // R1 reset state
    chk(a_out == '0 && b1_out == '0 && b2_out == '0, "R1 data", {a_out, b1_out}, 0);
    chk(!a_drive && !b_drive, "R1 drive", {a_drive, b_drive}, 0);
    rst = 1'b0;
    step();

    // R2 R3 R4 R5 gather sweep
    exp1 = '0; exp2 = '0;
    for (int k = 0; k < 64; k++) begin
      logic [W-1:0] w0, w1;
      w0 = W'((k * 37 + 5) & MASK);
      w1 = W'((~(k * 37 + 5) ^ (k << 3)) & MASK);
      a_in = w0; ab1_ld_n = 1'b0; ab2_ld_n = 1'b1;
      step();
      chk(b1_out == exp1 && b2_out == exp2, "R4 one edge not enough", b1_out, exp1);
      a_in = w1; ab1_ld_n = 1'b1; ab2_ld_n = 1'b0;
      step();
      chk(b1_out == w0, "R2 1B gets first word", b1_out, w0);
      chk(b2_out == w1, "R3 2B gets second word", b2_out, w1);
      exp1 = w0; exp2 = w1;
      // R5 hold with A moving and first stage loading
      ab2_ld_n = 1'b1; ab1_ld_n = 1'(k & 1); a_in = ~w1;
      step();
      chk(b1_out == exp1 && b2_out == exp2, "R5 hold", b2_out, exp2);
    end
    ab1_ld_n = 1'b1;

    // R6 R7 R8 pick sweep
    st1 = '0; st2 = '0; expa = a_out;
    for (int k = 0; k < 64; k++) begin
      logic [W-1:0] p, q;
      p = W'((k * 91 + 3) & MASK);
      q = W'((k * 53 + 700) & MASK);
      // case order per k: load patterns chosen from k bits
      b1_in = p; b2_in = q;
      b1a_ld_n = 1'(k & 1); b2a_ld_n = 1'((k >> 1) & 1); sel = 1'((k >> 2) & 1);
      if (!b1a_ld_n) st1 = p;
      if (!b2a_ld_n) st2 = q;
      if (!b1a_ld_n || !b2a_ld_n) expa = sel ? st1 : st2;
      step();
      if (b1a_ld_n && b2a_ld_n)
        chk(a_out == expa, "R8 hold both disabled", a_out, expa);
      else
        chk(a_out == expa, "R7 selected store", a_out, expa);
      // R6 read back each store through the select
      b1_in = ~p; b2_in = ~q;
      b1a_ld_n = 1'b1; b2a_ld_n = 1'b0; sel = 1'b1;
      st2 = ~q; expa = st1;
      step();
      chk(a_out == expa, "R6 1B store kept", a_out, expa);
      b1a_ld_n = 1'b1; b2a_ld_n = 1'b1; sel = 1'b0;
      step();
      chk(a_out == expa, "R8 sel change ignored", a_out, expa);
      b1a_ld_n = 1'b0; b2a_ld_n = 1'b1; sel = 1'b0; b1_in = p ^ 12'h0f0;
      st1 = p ^ 12'h0f0; expa = st2;
      step();
      chk(a_out == expa, "R6 2B store kept", a_out, expa);
    end
    b1a_ld_n = 1'b1; b2a_ld_n = 1'b1;

    // R9 R10 drive flags
    for (int k = 0; k < 8; k++) begin
      logic pa, pb;
      pa = a_drive; pb = b_drive;
      a_oe_n = 1'(k & 1); b_oe_n = 1'((k >> 1) & 1);
      #1;
      chk(a_drive == pa && b_drive == pb, "R9 no change before edge", {a_drive, b_drive}, {pa, pb});
      step();
      chk(a_drive == !a_oe_n, "R9 a_drive", a_drive, !a_oe_n);
      chk(b_drive == !b_oe_n, "R10 b_drive", b_drive, !b_oe_n);
    end

    // R1 reset between gather captures clears first stage
    a_in = 12'h5a5; ab1_ld_n = 1'b0;
    step();
    ab1_ld_n = 1'b1; rst = 1'b1;
    step();
    chk(!a_drive && !b_drive && a_out == '0, "R1 mid reset", a_out, 0);
    rst = 1'b0; a_in = 12'h3c3; ab2_ld_n = 1'b0;
    step();
    chk(b1_out == '0, "R1 first stage cleared", b1_out, 0);
    chk(b2_out == 12'h3c3, "R3 after reset", b2_out, 12'h3c3);
    ab2_ld_n = 1'b1;
    step();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule